// File: doc/BRIEF.md
# Interrupt Redirection Table Controller

This block gathers a vector of level-sensitive interrupt lines coming from a bus bridge and turns them into message writes. Each line owns a pair of words in a redirection table: a control word that holds the mask flag, the trigger and polarity flags, a delivery-mode flag and a 6-bit vector, and a destination word that holds a target address in swizzled form. Software reaches the table indirectly. It writes an entry number to a select register and then reads or writes a window register.

When an unmasked line with a nonzero destination goes active, the controller sets a bit in a pending mask. If that bit was clear, it queues one message that carries the line's vector to the line's unswizzled 64-bit destination. A line that stays asserted does not produce further messages. Deasserting or masking the line, or clearing its destination, drops the pending bit. Software can also drop pending bits by vector through an end-of-interrupt register.

Messages leave through a valid/ready port. Lines that become active together are served lowest index first.

Top module: `irq_redir`

## Requirements
- R1: The register port decodes word offsets 0 (select), 1 (window) and 2 (end-of-interrupt). Any other offset is answered with an error. Every request gets its response on `rsp_valid_o` exactly one cycle later. Write responses and error responses carry zero data.
- R2: A window access whose select value is at or above the table depth (16 + 2·N_IRQ) is an error. Such a write changes nothing and such a read returns zero.
- R3: Select value 1 reads back a version word: the table depth in bits 31:16 and 1 in the low bits. It cannot be written. The other select values below 16 read zero and ignore writes. The control word keeps bits 16:0 only, and bits 31:17 read zero.
- R4: After reset the select register is 0 and the pending mask is empty. Every control word of input n is 0x1A000 | (n+2): bit 16 mask, bit 15 level, bit 13 active-low, vector n+2. Every destination word holds RST_DEST (default 0xB0FF0000).
- R5: Input n uses control word 16+2n and destination word 17+2n. Input n becomes active when its line is high, control bit 16 is clear and its destination is nonzero. On that rising edge, the controller sets pending bit (vector mod N_IRQ), where the vector is control bits 5:0. A message is queued only if that bit was clear. The message data is the 6-bit vector, zero-extended.
- R6: When an active input stops being active, pending bit (vector mod N_IRQ) is cleared. This happens when the line falls, when the input is masked or when its destination becomes zero.
- R7: The message address is {32'hFFFFFFFF, 4'hF, d[23:16], d[31:24], 12'h000}, where d is the destination word.
- R8: A write to the end-of-interrupt register takes wdata bits 5:0. For every input n whose vector equals that value, pending bit n is cleared. Other bits are kept. A line held high does not re-fire after this.
- R9: While `msg_valid_o` is high and `msg_ready_i` is low, the message address and data do not change.
- R10: Queued messages are issued lowest input index first. The vector and destination are read from the table when the message is loaded into the output register.
- R11: A line held high produces exactly one message. The message appears two cycles after the rising edge is sampled, provided the output is free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | N_IRQ | Interrupt lines, active high (N_IRQ must be a power of two, at least 2) |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | ADDR_W | Register word offset |
| wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid, one cycle after a request |
| rdata_o | output | 32 | Read data |
| err_o | output | 1 | Unmapped access |
| msg_valid_o | output | 1 | Message write pending on the output |
| msg_addr_o | output | 64 | Message destination address |
| msg_data_o | output | 32 | Message data (vector in bits 5:0) |
| msg_ready_i | input | 1 | Message accepted when high with valid |
| pend_o | output | N_IRQ | Pending mask |

## Verification
The assertions rely on the message consumer and the register master behaving legally. `msg_ready_i` may stall the output for any number of cycles, but the register master drives one request per cycle with stable data and never issues a request during reset. The bench drives all inputs on the falling edge, so they are stable at the sampling edge. Its directed sequences use only the documented word offsets and select values. These include the out-of-range and reserved values that appear in R2 and R3.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;
  localparam int VEC_W    = 6;
  localparam int LOW_W    = 17;
  localparam int TBL_BASE = 16;
  localparam int MASK_BIT = 16;

  // register word offsets
  localparam int OFF_SEL = 0;
  localparam int OFF_WIN = 1;
  localparam int OFF_EOI = 2;

  // control word reset: mask | level | active-low
  localparam logic [LOW_W-1:0] LOW_RST = 17'h1A000;

  function automatic logic [63:0] dest_unswizzle(input logic [31:0] d);
    logic [31:0] lo;
    lo = ((d << 4) & 32'h0ff0_0000) | ((d >> 12) & 32'h000f_f000) | 32'hf000_0000;
    return {32'hffff_ffff, lo};
  endfunction
endpackage

// File: rtl/irq_redir_table.sv
module irq_redir_table
  import irq_redir_pkg::*;
#(
  parameter int          N_IRQ    = 8,
  parameter int          ADDR_W   = 4,
  parameter int          SEL_W    = 8,
  parameter logic [31:0] RST_DEST = 32'hb0ff_0000
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic                         rsp_valid_o,
  output logic [31:0]                  rdata_o,
  output logic                         err_o,
  output logic                         eoi_o,
  output logic [VEC_W-1:0]             eoi_vec_o,
  output logic [N_IRQ-1:0]             mask_o,
  output logic [N_IRQ-1:0][VEC_W-1:0]  vec_o,
  output logic [N_IRQ-1:0][31:0]       dest_o
);
  localparam int          DEPTH   = TBL_BASE + 2 * N_IRQ;
  localparam logic [31:0] VERSION = (32'(DEPTH) << 16) | 32'd1;

  logic [SEL_W-1:0] sel_q;
  logic [LOW_W-1:0] low_q  [N_IRQ];
  logic [31:0]      high_q [N_IRQ];

  logic             hit_sel, hit_win, hit_eoi;
  logic             win_ok, in_tbl, wr_win;
  logic [SEL_W-1:0] rel;
  logic [SEL_W-2:0] ent;
  logic [31:0]      rd_d;
  logic             err_d;
  logic             rsp_valid_q, err_q;
  logic [31:0]      rdata_q;

  assign hit_sel = addr_i == ADDR_W'(OFF_SEL);
  assign hit_win = addr_i == ADDR_W'(OFF_WIN);
  assign hit_eoi = addr_i == ADDR_W'(OFF_EOI);

  assign win_ok = sel_q < SEL_W'(DEPTH);
  assign in_tbl = win_ok && (sel_q >= SEL_W'(TBL_BASE));
  assign rel    = sel_q - SEL_W'(TBL_BASE);
  assign ent    = rel[SEL_W-1:1];
  assign wr_win = req_i & we_i & hit_win & in_tbl;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= '0;
    end else if (req_i && we_i && hit_sel) begin
      sel_q <= wdata_i[SEL_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int n = 0; n < N_IRQ; n++) begin
        low_q[n]  <= LOW_RST | LOW_W'(n + 2);
        high_q[n] <= RST_DEST;
      end
    end else if (wr_win) begin
      for (int n = 0; n < N_IRQ; n++) begin
        if (ent == (SEL_W-1)'(n)) begin
          if (rel[0]) high_q[n] <= wdata_i;
          else        low_q[n]  <= wdata_i[LOW_W-1:0];
        end
      end
    end
  end

  always_comb begin
    rd_d  = '0;
    err_d = 1'b0;
    if (hit_sel) begin
      rd_d = 32'(sel_q);
    end else if (hit_win) begin
      if (!win_ok) begin
        err_d = 1'b1;
      end else if (sel_q == SEL_W'(1)) begin
        rd_d = VERSION;
      end else if (in_tbl) begin
        for (int n = 0; n < N_IRQ; n++) begin
          if (ent == (SEL_W-1)'(n)) rd_d = rel[0] ? high_q[n] : 32'(low_q[n]);
        end
      end
    end else if (!hit_eoi) begin
      err_d = 1'b1;
    end
    if (we_i || err_d) rd_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_q <= 1'b0;
      rdata_q     <= '0;
      err_q       <= 1'b0;
    end else begin
      rsp_valid_q <= req_i;
      rdata_q     <= req_i ? rd_d : '0;
      err_q       <= req_i & err_d;
    end
  end

  assign rsp_valid_o = rsp_valid_q;
  assign rdata_o     = rdata_q;
  assign err_o       = err_q;
  assign eoi_o       = req_i & we_i & hit_eoi;
  assign eoi_vec_o   = wdata_i[VEC_W-1:0];

  for (genvar n = 0; n < N_IRQ; n++) begin : g_fld
    assign mask_o[n] = low_q[n][MASK_BIT];
    assign vec_o[n]  = low_q[n][VEC_W-1:0];
    assign dest_o[n] = high_q[n];
  end
endmodule

// File: rtl/irq_redir_pend.sv
module irq_redir_pend
  import irq_redir_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_IRQ-1:0]            irq_i,
  input  logic [N_IRQ-1:0]            mask_i,
  input  logic [N_IRQ-1:0][VEC_W-1:0] vec_i,
  input  logic [N_IRQ-1:0][31:0]      dest_i,
  input  logic                        eoi_i,
  input  logic [VEC_W-1:0]            eoi_vec_i,
  output logic [N_IRQ-1:0]            pend_o,
  output logic [N_IRQ-1:0]            owe_set_o
);
  localparam int IDX_W = $clog2(N_IRQ);

  logic [N_IRQ-1:0] act, act_q, pend_q, pend_d, owe_d;

  for (genvar n = 0; n < N_IRQ; n++) begin : g_act
    assign act[n] = irq_i[n] & ~mask_i[n] & (|dest_i[n]);
  end

  // eoi first, then edges in input order
  always_comb begin
    pend_d = pend_q;
    owe_d  = '0;
    if (eoi_i) begin
      for (int n = 0; n < N_IRQ; n++) begin
        if (vec_i[n] == eoi_vec_i) pend_d[n] = 1'b0;
      end
    end
    for (int n = 0; n < N_IRQ; n++) begin
      if (act_q[n] && !act[n]) begin
        pend_d[vec_i[n][IDX_W-1:0]] = 1'b0;
      end else if (!act_q[n] && act[n]) begin
        if (!pend_d[vec_i[n][IDX_W-1:0]]) owe_d[n] = 1'b1;
        pend_d[vec_i[n][IDX_W-1:0]] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= '0;
      pend_q <= '0;
    end else begin
      act_q  <= act;
      pend_q <= pend_d;
    end
  end

  assign pend_o    = pend_q;
  assign owe_set_o = owe_d;
endmodule

// File: rtl/irq_redir_msg.sv
module irq_redir_msg
  import irq_redir_pkg::*;
#(
  parameter int N_IRQ = 8
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [N_IRQ-1:0]            owe_set_i,
  input  logic [N_IRQ-1:0][VEC_W-1:0] vec_i,
  input  logic [N_IRQ-1:0][31:0]      dest_i,
  input  logic                        ready_i,
  output logic                        valid_o,
  output logic [63:0]                 addr_o,
  output logic [31:0]                 data_o
);
  logic [N_IRQ-1:0] owe_q, pop;
  logic [VEC_W-1:0] vec_sel;
  logic [31:0]      dest_sel;
  logic             load, any;
  logic             valid_q;
  logic [63:0]      addr_q;
  logic [31:0]      data_q;

  // lowest index wins
  always_comb begin
    pop      = '0;
    vec_sel  = '0;
    dest_sel = '0;
    for (int n = N_IRQ - 1; n >= 0; n--) begin
      if (owe_q[n]) begin
        pop      = '0;
        pop[n]   = 1'b1;
        vec_sel  = vec_i[n];
        dest_sel = dest_i[n];
      end
    end
  end

  assign any  = |owe_q;
  assign load = ~valid_q | ready_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owe_q   <= '0;
      valid_q <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      owe_q <= (owe_q & ~(load ? pop : '0)) | owe_set_i;
      if (load) begin
        valid_q <= any;
        if (any) begin
          addr_q <= dest_unswizzle(dest_sel);
          data_q <= 32'(vec_sel);
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign addr_o  = addr_q;
  assign data_o  = data_q;
endmodule

// File: rtl/irq_redir.sv
module irq_redir
  import irq_redir_pkg::*;
#(
  parameter int          N_IRQ    = 8,
  parameter int          ADDR_W   = 4,
  parameter int          SEL_W    = 8,
  parameter logic [31:0] RST_DEST = 32'hb0ff_0000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [31:0]       wdata_i,
  output logic              rsp_valid_o,
  output logic [31:0]       rdata_o,
  output logic              err_o,
  output logic              msg_valid_o,
  output logic [63:0]       msg_addr_o,
  output logic [31:0]       msg_data_o,
  input  logic              msg_ready_i,
  output logic [N_IRQ-1:0]  pend_o
);
  logic                        eoi;
  logic [VEC_W-1:0]            eoi_vec;
  logic [N_IRQ-1:0]            mask;
  logic [N_IRQ-1:0][VEC_W-1:0] vec;
  logic [N_IRQ-1:0][31:0]      dest;
  logic [N_IRQ-1:0]            owe_set;

  irq_redir_table #(
    .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .SEL_W(SEL_W), .RST_DEST(RST_DEST)
  ) u_table (
    .clk_i, .rst_ni, .req_i, .we_i, .addr_i, .wdata_i,
    .rsp_valid_o, .rdata_o, .err_o,
    .eoi_o(eoi), .eoi_vec_o(eoi_vec),
    .mask_o(mask), .vec_o(vec), .dest_o(dest)
  );

  irq_redir_pend #(.N_IRQ(N_IRQ)) u_pend (
    .clk_i, .rst_ni, .irq_i,
    .mask_i(mask), .vec_i(vec), .dest_i(dest),
    .eoi_i(eoi), .eoi_vec_i(eoi_vec),
    .pend_o, .owe_set_o(owe_set)
  );

  irq_redir_msg #(.N_IRQ(N_IRQ)) u_msg (
    .clk_i, .rst_ni, .owe_set_i(owe_set),
    .vec_i(vec), .dest_i(dest),
    .ready_i(msg_ready_i),
    .valid_o(msg_valid_o), .addr_o(msg_addr_o), .data_o(msg_data_o)
  );
endmodule

// File: rtl/irq_redir_chk.sv
module irq_redir_chk #(
  parameter int N_IRQ = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              rsp_valid_o,
  input logic              err_o,
  input logic              msg_valid_o,
  input logic [63:0]       msg_addr_o,
  input logic [31:0]       msg_data_o,
  input logic              msg_ready_i,
  input logic [N_IRQ-1:0]  pend_o
);
  AST_RSP_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o); // R1
  AST_RSP_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> !rsp_valid_o); // R1
  AST_ERR_IN_RSP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> rsp_valid_o); // R1
  AST_MSG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_addr_o) && $stable(msg_data_o)); // R9
  AST_MSG_ADDR_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_addr_o[63:28] == 36'hf_ffff_ffff && msg_addr_o[11:0] == 12'h000); // R7
  AST_MSG_VEC_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:6] == '0); // R5
  AST_PEND_KNOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(pend_o)); // R5
endmodule

bind irq_redir irq_redir_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i),
  .rsp_valid_o(rsp_valid_o), .err_o(err_o),
  .msg_valid_o(msg_valid_o), .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o),
  .msg_ready_i(msg_ready_i), .pend_o(pend_o)
);

// File: tb/irq_redir_bench.sv
`timescale 1ns/1ps
module irq_redir_bench;
  localparam int N = 8;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [N-1:0] irq = '0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        rsp_valid, err;
  logic [31:0] rdata;
  logic        msg_valid, msg_ready = 1'b1;
  logic [63:0] msg_addr;
  logic [31:0] msg_data;
  logic [N-1:0] pend;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  irq_redir u_irq_redir (
    .clk_i(clk), .rst_ni(rst_n), .irq_i(irq), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rsp_valid_o(rsp_valid), .rdata_o(rdata),
    .err_o(err), .msg_valid_o(msg_valid), .msg_addr_o(msg_addr),
    .msg_data_o(msg_data), .msg_ready_i(msg_ready), .pend_o(pend)
  );

  task automatic chk(input string rq, input string what, input longint act, input longint exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int unsigned m_tbl[DEPTH];
  int unsigned m_sel;
  bit [N-1:0]  m_act, m_pend, m_owe;
  bit          m_mv, m_rv, m_re;
  longint unsigned m_maddr;
  int unsigned m_mdata, m_rd;

  function automatic longint unsigned ref_addr(input int unsigned d);
    bit [31:0] b;
    b = d;
    return {32'hffff_ffff, 4'hf, b[23:16], b[31:24], 12'h000};
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) m_tbl[i] = 0;
      for (int n = 0; n < N; n++) begin
        m_tbl[16 + 2*n] = 32'h1A000 + n + 2;
        m_tbl[17 + 2*n] = 32'hb0ff0000;
      end
      m_sel = 0; m_act = 0; m_pend = 0; m_owe = 0;
      m_mv = 0; m_maddr = 0; m_mdata = 0; m_rv = 0; m_re = 0; m_rd = 0;
    end else begin
      bit [N-1:0] now;
      bit found;
      if (!m_mv || msg_ready) begin
        m_mv = 0; found = 0;
        for (int k = 0; k < N; k++) begin
          if (m_owe[k] && !found) begin
            found = 1; m_mv = 1;
            m_mdata = m_tbl[16 + 2*k] & 63;
            m_maddr = ref_addr(m_tbl[17 + 2*k]);
            m_owe[k] = 0;
          end
        end
      end
      for (int n = 0; n < N; n++)
        now[n] = irq[n] && !m_tbl[16 + 2*n][16] && (m_tbl[17 + 2*n] != 0);
      if (req && we && addr == 2) begin
        for (int n = 0; n < N; n++)
          if ((m_tbl[16 + 2*n] & 63) == (wdata & 63)) m_pend[n] = 0;
      end
      for (int n = 0; n < N; n++) begin
        int b;
        b = m_tbl[16 + 2*n] % N;
        if (m_act[n] && !now[n]) m_pend[b] = 0;
        else if (!m_act[n] && now[n]) begin
          if (!m_pend[b]) m_owe[n] = 1;
          m_pend[b] = 1;
        end
      end
      m_act = now;
      m_rv = req; m_re = 0; m_rd = 0;
      if (req) begin
        case (addr)
          4'd0: if (we) m_sel = wdata & 255; else m_rd = m_sel;
          4'd1: begin
            if (m_sel >= DEPTH) m_re = 1;
            else if (m_sel >= 16) begin
              if (we) m_tbl[m_sel] = (m_sel % 2 == 0) ? (wdata & 32'h1FFFF) : wdata;
              else m_rd = m_tbl[m_sel];
            end else if (m_sel == 1 && !we) m_rd = (DEPTH << 16) | 1;
          end
          4'd2: ;
          default: m_re = 1;
        endcase
      end
    end
  end

  // ---------------- per-cycle compare and message monitor ----------------
  int unsigned got_vec[$];
  longint unsigned got_addr[$];

  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk("R5", "pending mask", pend, m_pend);
      chk("R9", "msg valid", msg_valid, m_mv);
      if (m_mv) begin
        chk("R7", "msg addr", msg_addr, m_maddr);
        chk("R10", "msg data", msg_data, m_mdata);
      end
      chk("R1", "rsp valid", rsp_valid, m_rv);
      if (m_rv) begin
        chk("R1", "rsp err", err, m_re);
        chk("R1", "rsp data", rdata, m_rd);
      end
      if (msg_valid && msg_ready) begin
        got_vec.push_back(msg_data);
        got_addr.push_back(msg_addr);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus(input bit w, input int a, input int unsigned d,
                     output int unsigned rd, output bit e);
    @(negedge clk);
    req = 1; we = w; addr = a[3:0]; wdata = d;
    @(negedge clk);
    req = 0; we = 0;
    #1;
    rd = rdata; e = err;
  endtask

  task automatic wr(input int a, input int unsigned d);
    int unsigned rd; bit e;
    bus(1, a, d, rd, e);
  endtask

  task automatic win_wr(input int idx, input int unsigned d);
    wr(0, idx);
    wr(1, d);
  endtask

  task automatic win_rd(input int idx, output int unsigned rd, output bit e);
    wr(0, idx);
    bus(0, 1, 0, rd, e);
  endtask

  task automatic wait_cyc(input int c);
    repeat (c) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned rd; bit e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    wait_cyc(1);
    chk("R4", "pend after reset", pend, 0);
    chk("R4", "msg valid after reset", msg_valid, 0);
    bus(0, 0, 0, rd, e);
    chk("R4", "select reset", rd, 0);
    win_rd(16, rd, e);
    chk("R4", "ctrl word 0 reset", rd, 32'h1A002);
    win_rd(30, rd, e);
    chk("R4", "ctrl word 7 reset", rd, 32'h1A009);
    win_rd(23, rd, e);
    chk("R4", "dest word 3 reset", rd, 32'hb0ff0000);

    win_rd(1, rd, e);
    chk("R3", "version", rd, 32'h0020_0001);
    win_wr(1, 32'hdead);
    win_rd(1, rd, e);
    chk("R3", "version read only", rd, 32'h0020_0001);
    win_wr(5, 32'h55);
    win_rd(5, rd, e);
    chk("R3", "reserved index reads zero", rd, 0);
    win_wr(16, 32'hFFFF_FFFF);
    win_rd(16, rd, e);
    chk("R3", "ctrl word upper bits", rd, 32'h1FFFF);
    win_wr(16, 32'h1A002);

    win_rd(32, rd, e);
    chk("R2", "beyond table err", e, 1);
    chk("R2", "beyond table data", rd, 0);
    win_wr(64, 32'h1234);
    bus(0, 1, 0, rd, e);
    chk("R2", "beyond table write err", e, 1);
    bus(0, 3, 0, rd, e);
    chk("R1", "unmapped offset 3", e, 1);
    bus(1, 15, 0, rd, e);
    chk("R1", "unmapped offset 15", e, 1);

    // masked input is ignored
    got_vec.delete();
    irq[0] = 1;
    wait_cyc(5);
    chk("R5", "masked no message", got_vec.size(), 0);
    chk("R5", "masked no pending", pend, 0);
    irq[0] = 0;

    // input 0: vector 0x20, destination 0x12345678
    win_wr(16, 32'h8020);
    win_wr(17, 32'h12345678);
    got_vec.delete(); got_addr.delete();
    wait_cyc(2);
    irq[0] = 1;
    wait_cyc(6);
    chk("R11", "one message on rise", got_vec.size(), 1);
    if (got_vec.size() > 0) begin
      chk("R5", "vector carried", got_vec[0], 32'h20);
      chk("R7", "unswizzled addr", got_addr[0], 64'hffff_ffff_f341_2000);
    end
    chk("R5", "pending bit 0", pend, 8'h01);
    wait_cyc(20);
    chk("R11", "held level no repeat", got_vec.size(), 1);

    wr(2, 32'h21);
    wait_cyc(1);
    chk("R8", "eoi mismatch keeps bit", pend, 8'h01);
    wr(2, 32'h60);
    wait_cyc(1);
    chk("R8", "eoi match clears bit", pend, 8'h00);
    wait_cyc(6);
    chk("R8", "no refire after eoi", got_vec.size(), 1);

    irq[0] = 0;
    wait_cyc(2);
    chk("R6", "fall clears", pend, 0);
    irq[0] = 1;
    wait_cyc(6);
    chk("R6", "re-rise fires again", got_vec.size(), 2);
    win_wr(16, 32'h18020);
    wait_cyc(2);
    chk("R6", "mask clears pending", pend, 0);
    irq[0] = 0;

    // ordering and hold
    win_wr(18, 32'h8001);
    win_wr(20, 32'h8002);
    win_wr(22, 32'h8003);
    got_vec.delete();
    @(negedge clk);
    msg_ready = 0;
    irq[3:1] = 3'b111;
    wait_cyc(6);
    chk("R10", "first served lowest", msg_data, 1);
    wait_cyc(4);
    chk("R9", "held while stalled", msg_valid, 1);
    chk("R9", "data stable while stalled", msg_data, 1);
    @(negedge clk);
    msg_ready = 1;
    wait_cyc(6);
    chk("R10", "three messages", got_vec.size(), 3);
    if (got_vec.size() == 3) begin
      chk("R10", "order 2nd", got_vec[1], 2);
      chk("R10", "order 3rd", got_vec[2], 3);
    end
    chk("R5", "pending bits 1..3", pend, 8'h0e);

    // shared pending bit: no message
    win_wr(26, 32'h8009);
    got_vec.delete();
    irq[5] = 1;
    wait_cyc(6);
    chk("R5", "shared bit no message", got_vec.size(), 0);
    chk("R5", "shared bit pending", pend, 8'h0e);

    // zero destination never activates
    win_wr(28, 32'h8006);
    win_wr(29, 0);
    irq[6] = 1;
    wait_cyc(6);
    chk("R6", "zero dest no message", got_vec.size(), 0);
    chk("R6", "zero dest no pending", pend[6], 0);

    irq = '0;
    wait_cyc(4);
    chk("R6", "all low clears", pend, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule